// File: doc/BRIEF.md
# Memory-Mapped Disk Register Bridge

This block sits between a simple processor bus and the register port of an ATA-style disk controller. It maps a 4 KB window onto the task-file register set, with each register placed on a 16-byte stride. Each bus access is decoded and forwarded as a single strobe on a downstream register port. The port has separate strobes for task-file reads and writes, device-control writes, alternate-status reads, and 16-bit and 32-bit data transfers.

Wide accesses to the data register are byte-reversed in both directions, so that the bus and the drive side see their native byte order. Accesses that fall outside the register map raise no strobe. Writes to such addresses vanish. Reads from them return all ones at the width of the access. Read data reaches the bus one cycle after the read request and is held until the next read.

Top module: `disk_reg_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] never change the decode or the data.
- R2: A byte access (size code 0) at index 1 to 7 raises `dn_tf_rd` for a read or `dn_tf_wr` for a write, with `dn_idx` equal to the index. A byte read returns `{24'h0, dn_rdata[7:0]}`.
- R3: A byte write at index 8 or 22 raises `dn_ctl_wr`, with `dn_wdata = {24'h0, bus_wdata[7:0]}`. A byte read at index 8 or 22 raises `dn_alt_rd` and returns `{24'h0, dn_rdata[7:0]}`.
- R4: A halfword access (size code 1) at index 0 raises `dn_d16_wr` or `dn_d16_rd`. The two low bytes are exchanged: the write data is `{16'h0, wdata[7:0], wdata[15:8]}` and the read data is `{16'h0, dn_rdata[7:0], dn_rdata[15:8]}`.
- R5: A word access (size code 2) at index 0 raises `dn_d32_wr` or `dn_d32_rd`. All four bytes are reversed on both the write data and the read data.
- R6: An unmapped read returns 0x000000FF for a byte access, 0x0000FFFF for a halfword access, and 0xFFFFFFFF for a word access or the reserved size code 3.
- R7: The following accesses are unmapped and raise no downstream strobe: a byte access at index 0 or above 22, a byte access at any index from 9 to 21, a wide access at any nonzero index, and any access with size code 3. Unmapped writes are dropped.
- R8: At most one downstream strobe is high in any cycle.
- R9: `bus_rdata` is 0 after reset. It updates on the clock edge that ends a read cycle and holds its value in every other cycle.
- R10: When `bus_wr` and `bus_rd` are both high, the access is treated as a write only. `bus_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read |
| dn_idx | output | 3 | Task-file register index |
| dn_tf_rd | output | 1 | Task-file read strobe |
| dn_tf_wr | output | 1 | Task-file write strobe |
| dn_ctl_wr | output | 1 | Device-control write strobe |
| dn_alt_rd | output | 1 | Alternate-status read strobe |
| dn_d16_rd | output | 1 | 16-bit data read strobe |
| dn_d16_wr | output | 1 | 16-bit data write strobe |
| dn_d32_rd | output | 1 | 32-bit data read strobe |
| dn_d32_wr | output | 1 | 32-bit data write strobe |
| dn_wdata | output | 32 | Write data toward the register port |
| dn_rdata | input | 32 | Read data from the register port, same cycle as the strobe |

## Verification
The assertions check on every cycle the rules that can be judged from the current access alone:
- each strobe appears only for the index and size that permit it;
- at most one strobe is high;
- a byte read at index 0 yields 0xFF one cycle later;
- `bus_rdata` stays unchanged when no read was accepted.

The following can only be shown by the bench scenarios:
- the exact byte reversal of halfword and word data in both directions;
- the width-dependent all-ones values for every unmapped class;
- that the low address bits are ignored;
- that write wins over read when both requests are high.

// File: rtl/drb_pkg.sv
package drb_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int IDX_LSB  = 4;
    localparam int IDX_W    = ADDR_W - IDX_LSB;
    localparam int TF_IDX_W = 3;
    localparam int BYTE_W   = 8;

    // Register indices with a fixed meaning in the window
    localparam logic [IDX_W-1:0] DATA_IDX   = IDX_W'(0);
    localparam logic [IDX_W-1:0] TF_FIRST   = IDX_W'(1);
    localparam logic [IDX_W-1:0] TF_LAST    = IDX_W'(7);
    localparam logic [IDX_W-1:0] CTL_IDX_LO = IDX_W'(8);
    localparam logic [IDX_W-1:0] CTL_IDX_HI = IDX_W'(22);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE     = 3'd0,
        TGT_TASKFILE = 3'd1,
        TGT_CONTROL  = 3'd2,
        TGT_DATA16   = 3'd3,
        TGT_DATA32   = 3'd4
    } target_e;

    typedef struct packed {
        target_e               tgt;
        logic [TF_IDX_W-1:0]   tf_idx;
    } decode_t;

    typedef struct packed {
        logic tf_rd;
        logic tf_wr;
        logic ctl_wr;
        logic alt_rd;
        logic d16_rd;
        logic d16_wr;
        logic d32_rd;
        logic d32_wr;
    } strobes_t;

    // All-ones read value for an unmapped access of the given size
    function automatic logic [DATA_W-1:0] unmapped_fill(acc_size_e sz);
        logic [DATA_W-1:0] v;
        case (sz)
            SZ_BYTE: v = {{(DATA_W-8){1'b0}},  8'hFF};
            SZ_HALF: v = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: v = {DATA_W{1'b1}};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/drb_lane_swap.sv
module drb_lane_swap #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    // Byte reversal: lane i of the output takes lane LANES-1-i of the input
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/drb_decode.sv
module drb_decode
    import drb_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  acc_size_e     size,
    output decode_t       dec
);
    localparam int IW = AW - IDX_LSB;

    logic [IW-1:0] idx;
    logic          is_tf_range;
    logic          is_ctl_idx;
    logic          is_data_idx;

    // Only bits [AW-1:IDX_LSB] select a register; the low nibble is dropped
    assign idx         = addr[AW-1:IDX_LSB];
    assign is_tf_range = (idx >= IW'(TF_FIRST)) && (idx <= IW'(TF_LAST));
    assign is_ctl_idx  = (idx == IW'(CTL_IDX_LO)) || (idx == IW'(CTL_IDX_HI));
    assign is_data_idx = (idx == IW'(DATA_IDX));

    always_comb begin
        dec.tgt    = TGT_NONE;
        dec.tf_idx = '0;
        case (size)
            SZ_BYTE: begin
                if (is_tf_range) begin
                    dec.tgt    = TGT_TASKFILE;
                    dec.tf_idx = idx[TF_IDX_W-1:0];
                end else if (is_ctl_idx) begin
                    dec.tgt = TGT_CONTROL;
                end
            end
            SZ_HALF: if (is_data_idx) dec.tgt = TGT_DATA16;
            SZ_WORD: if (is_data_idx) dec.tgt = TGT_DATA32;
            default: dec.tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/drb_read_stage.sv
module drb_read_stage
    import drb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_fire,
    input  acc_size_e     size,
    input  target_e       tgt,
    input  logic [DW-1:0] dn_rdata,
    output logic [DW-1:0] rdata
);
    logic [15:0]   sw16;
    logic [DW-1:0] sw32;
    logic [DW-1:0] rd_next;

    drb_lane_swap #(.LANES(2), .LANE_W(BYTE_W)) u_sw16 (
        .din  (dn_rdata[15:0]),
        .dout (sw16)
    );

    drb_lane_swap #(.LANES(DW/BYTE_W), .LANE_W(BYTE_W)) u_sw32 (
        .din  (dn_rdata),
        .dout (sw32)
    );

    always_comb begin
        case (tgt)
            TGT_TASKFILE,
            TGT_CONTROL: rd_next = {{(DW-BYTE_W){1'b0}}, dn_rdata[BYTE_W-1:0]};
            TGT_DATA16:  rd_next = {{(DW-16){1'b0}}, sw16};
            TGT_DATA32:  rd_next = sw32;
            default:     rd_next = DW'(unmapped_fill(size));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_fire) begin
            rdata <= rd_next;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> $stable(rdata)); // R9
endmodule

// File: rtl/disk_reg_bridge.sv
module disk_reg_bridge
    import drb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [2:0]    dn_idx,
    output logic          dn_tf_rd,
    output logic          dn_tf_wr,
    output logic          dn_ctl_wr,
    output logic          dn_alt_rd,
    output logic          dn_d16_rd,
    output logic          dn_d16_wr,
    output logic          dn_d32_rd,
    output logic          dn_d32_wr,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata
);
    acc_size_e     size;
    decode_t       dec;
    strobes_t      stb;
    logic          wr_fire;
    logic          rd_fire;
    logic [15:0]   wsw16;
    logic [DW-1:0] wsw32;

    assign size    = acc_size_e'(bus_size);
    // A write request takes precedence over a simultaneous read request
    assign wr_fire = bus_wr;
    assign rd_fire = bus_rd && !bus_wr;

    drb_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .size (size),
        .dec  (dec)
    );

    always_comb begin
        stb        = '0;
        stb.tf_rd  = rd_fire && (dec.tgt == TGT_TASKFILE);
        stb.tf_wr  = wr_fire && (dec.tgt == TGT_TASKFILE);
        stb.ctl_wr = wr_fire && (dec.tgt == TGT_CONTROL);
        stb.alt_rd = rd_fire && (dec.tgt == TGT_CONTROL);
        stb.d16_rd = rd_fire && (dec.tgt == TGT_DATA16);
        stb.d16_wr = wr_fire && (dec.tgt == TGT_DATA16);
        stb.d32_rd = rd_fire && (dec.tgt == TGT_DATA32);
        stb.d32_wr = wr_fire && (dec.tgt == TGT_DATA32);
    end

    assign dn_tf_rd  = stb.tf_rd;
    assign dn_tf_wr  = stb.tf_wr;
    assign dn_ctl_wr = stb.ctl_wr;
    assign dn_alt_rd = stb.alt_rd;
    assign dn_d16_rd = stb.d16_rd;
    assign dn_d16_wr = stb.d16_wr;
    assign dn_d32_rd = stb.d32_rd;
    assign dn_d32_wr = stb.d32_wr;
    assign dn_idx    = (stb.tf_rd || stb.tf_wr) ? dec.tf_idx : '0;

    // Write data: byte-reverse the wide data-port writes
    drb_lane_swap #(.LANES(2), .LANE_W(BYTE_W)) u_wsw16 (
        .din  (bus_wdata[15:0]),
        .dout (wsw16)
    );

    drb_lane_swap #(.LANES(DW/BYTE_W), .LANE_W(BYTE_W)) u_wsw32 (
        .din  (bus_wdata),
        .dout (wsw32)
    );

    always_comb begin
        case (size)
            SZ_BYTE: dn_wdata = {{(DW-BYTE_W){1'b0}}, bus_wdata[BYTE_W-1:0]};
            SZ_HALF: dn_wdata = {{(DW-16){1'b0}}, wsw16};
            default: dn_wdata = wsw32;
        endcase
    end

    drb_read_stage #(.DW(DW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_fire  (rd_fire),
        .size     (size),
        .tgt      (dec.tgt),
        .dn_rdata (dn_rdata),
        .rdata    (bus_rdata)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dn_tf_rd, dn_tf_wr, dn_ctl_wr, dn_alt_rd,
                  dn_d16_rd, dn_d16_wr, dn_d32_rd, dn_d32_wr})); // R8

    AST_TF_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (dn_tf_rd || dn_tf_wr) |-> (bus_size == 2'd0 && dn_idx != 3'd0
                                    && bus_addr[AW-1:7] == '0)); // R2

    AST_CTL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (dn_ctl_wr || dn_alt_rd) |-> (bus_size == 2'd0 &&
            (bus_addr[AW-1:4] == (AW-4)'(8) || bus_addr[AW-1:4] == (AW-4)'(22)))); // R3

    AST_WIDE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dn_d16_rd || dn_d16_wr || dn_d32_rd || dn_d32_wr)
            |-> (bus_addr[AW-1:4] == '0 && bus_size != 2'd0)); // R7

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> !(dn_tf_rd || dn_alt_rd || dn_d16_rd || dn_d32_rd)); // R10

    AST_BYTE0_FILL: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_size == 2'd0 && bus_addr[AW-1:4] == '0)
            |=> (bus_rdata == DW'(32'h0000_00FF))); // R6
endmodule

// File: tb/disk_reg_bridge_test.sv
module disk_reg_bridge_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0]  stb;
        logic [2:0]  idx;
        logic        chk_wd;
        logic [31:0] wd;
        logic [31:0] rd;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  dn_idx;
    logic        dn_tf_rd, dn_tf_wr, dn_ctl_wr, dn_alt_rd;
    logic        dn_d16_rd, dn_d16_wr, dn_d32_rd, dn_d32_wr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = 32'hA1B2C3D4;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_rd = '0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_reg_bridge uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dn_idx(dn_idx),
        .dn_tf_rd(dn_tf_rd), .dn_tf_wr(dn_tf_wr), .dn_ctl_wr(dn_ctl_wr),
        .dn_alt_rd(dn_alt_rd), .dn_d16_rd(dn_d16_rd), .dn_d16_wr(dn_d16_wr),
        .dn_d32_rd(dn_d32_rd), .dn_d32_wr(dn_d32_wr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Strobe vector order: tf_rd tf_wr ctl_wr alt_rd d16_rd d16_wr d32_rd d32_wr
    function automatic item_t model(input logic [11:0] a, input logic [1:0] sz,
                                    input logic wr, input logic rd,
                                    input logic [31:0] wd, input logic [31:0] dr,
                                    input string tag);
        item_t it;
        logic [7:0] ix;
        logic rdf;
        ix = a[11:4];
        rdf = rd && !wr;
        it.stb = 8'h00; it.idx = 3'd0; it.chk_wd = 1'b0; it.wd = '0; it.tag = tag;
        it.rd = last_rd;
        if (sz == 2'd0 && ix >= 8'd1 && ix <= 8'd7) begin
            if (wr) begin it.stb = 8'b0100_0000; it.chk_wd = 1'b1; it.wd = {24'h0, wd[7:0]}; end
            else if (rdf) begin it.stb = 8'b1000_0000; it.rd = {24'h0, dr[7:0]}; end
            if (wr || rdf) it.idx = ix[2:0];
        end else if (sz == 2'd0 && (ix == 8'd8 || ix == 8'd22)) begin
            if (wr) begin it.stb = 8'b0010_0000; it.chk_wd = 1'b1; it.wd = {24'h0, wd[7:0]}; end
            else if (rdf) begin it.stb = 8'b0001_0000; it.rd = {24'h0, dr[7:0]}; end
        end else if (sz == 2'd1 && ix == 8'd0) begin
            if (wr) begin it.stb = 8'b0000_0100; it.chk_wd = 1'b1; it.wd = {16'h0, wd[7:0], wd[15:8]}; end
            else if (rdf) begin it.stb = 8'b0000_1000; it.rd = {16'h0, dr[7:0], dr[15:8]}; end
        end else if (sz == 2'd2 && ix == 8'd0) begin
            if (wr) begin it.stb = 8'b0000_0001; it.chk_wd = 1'b1;
                it.wd = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]}; end
            else if (rdf) begin it.stb = 8'b0000_0010;
                it.rd = {dr[7:0], dr[15:8], dr[23:16], dr[31:24]}; end
        end else if (rdf) begin
            it.rd = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        end
        last_rd = it.rd;
        return it;
    endfunction

    task automatic acc(input logic [11:0] a, input logic [1:0] sz, input logic wr,
                       input logic rd, input logic [31:0] wd, input logic [31:0] dr,
                       input string tag);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wr = wr; bus_rd = rd;
        bus_wdata = wd; dn_rdata = dr;
        q.push_back(model(a, sz, wr, rd, wd, dr, tag));
    endtask

    task automatic idle(input string tag);
        acc(12'h000, 2'd0, 1'b0, 1'b0, 32'h0, 32'h5A5A5A5A, tag);
    endtask

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: the strobes stay valid until the next negedge; rdata was registered at this edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check32(it.tag, "strobes",
                    {24'h0, dn_tf_rd, dn_tf_wr, dn_ctl_wr, dn_alt_rd,
                     dn_d16_rd, dn_d16_wr, dn_d32_rd, dn_d32_wr}, {24'h0, it.stb});
                check32(it.tag, "dn_idx", {29'h0, dn_idx}, {29'h0, it.idx});
                if (it.chk_wd) check32(it.tag, "dn_wdata", dn_wdata, it.wd);
                check32(it.tag, "bus_rdata", bus_rdata, it.rd);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check32("R9", "reset rdata", bus_rdata, 32'h0);
        check32("R8", "reset strobes",
            {24'h0, dn_tf_rd, dn_tf_wr, dn_ctl_wr, dn_alt_rd,
             dn_d16_rd, dn_d16_wr, dn_d32_rd, dn_d32_wr}, 32'h0);

        // R2 task-file reads and writes at every index, low nibble varied (R1)
        for (int i = 1; i <= 7; i++) begin
            acc(12'((i << 4) | (i & 15)), 2'd0, 1'b0, 1'b1, 32'h0, 32'h1000_0000 + 32'(i * 17), "R2_rd");
            acc(12'((i << 4) | 15), 2'd0, 1'b1, 1'b0, 32'hDEAD_BE00 + 32'(i), 32'h0, "R2_wr");
        end
        // R3 control write and alternate-status read at both indices
        acc(12'h080, 2'd0, 1'b1, 1'b0, 32'h1234_5608, 32'h0, "R3_wr8");
        acc(12'h16C, 2'd0, 1'b1, 1'b0, 32'h0000_0004, 32'h0, "R3_wr22");
        acc(12'h085, 2'd0, 1'b0, 1'b1, 32'h0, 32'h7766_5550, "R3_rd8");
        acc(12'h163, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0000_00C8, "R3_rd22");
        // R4 halfword data port
        acc(12'h000, 2'd1, 1'b1, 1'b0, 32'hFFFF_ABCD, 32'h0, "R4_wr");
        acc(12'h00E, 2'd1, 1'b0, 1'b1, 32'h0, 32'h9999_1234, "R4_rd_R1");
        // R5 word data port
        acc(12'h000, 2'd2, 1'b1, 1'b0, 32'h0102_0304, 32'h0, "R5_wr");
        acc(12'h00C, 2'd2, 1'b0, 1'b1, 32'h0, 32'hA1B2_C3D4, "R5_rd_R1");
        // R6 / R7 unmapped reads
        acc(12'h000, 2'd0, 1'b0, 1'b1, 32'h0, 32'h1111_1111, "R7_byte0");
        acc(12'h090, 2'd0, 1'b0, 1'b1, 32'h0, 32'h2222_2222, "R6_byte9");
        acc(12'hFF0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h3333_3333, "R6_byte255");
        acc(12'h030, 2'd1, 1'b0, 1'b1, 32'h0, 32'h4444_4444, "R7_half3");
        acc(12'h200, 2'd2, 1'b0, 1'b1, 32'h0, 32'h5555_5555, "R7_word32");
        acc(12'h000, 2'd3, 1'b0, 1'b1, 32'h0, 32'h6666_6666, "R6_rsvd");
        // R7 unmapped writes raise nothing, and rdata stays held (R9)
        acc(12'h000, 2'd0, 1'b1, 1'b0, 32'h0000_00AA, 32'h0, "R7_wr_byte0");
        acc(12'h010, 2'd2, 1'b1, 1'b0, 32'hAAAA_AAAA, 32'h0, "R7_wr_word1");
        acc(12'h080, 2'd1, 1'b1, 1'b0, 32'hBBBB_BBBB, 32'h0, "R7_wr_half8");
        acc(12'h000, 2'd3, 1'b1, 1'b0, 32'hCCCC_CCCC, 32'h0, "R7_wr_rsvd");
        // R10 write wins over read
        acc(12'h020, 2'd0, 1'b1, 1'b1, 32'h0000_0077, 32'h0F0F_0F0F, "R10_tf");
        acc(12'h000, 2'd2, 1'b1, 1'b1, 32'h1122_3344, 32'h0F0F_0F0F, "R10_d32");
        // R9 hold across idle cycles
        idle("R9_idle");
        idle("R9_idle");
        acc(12'h050, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0000_00E5, "R9_rd");
        idle("R9_idle");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule